// File: doc/BRIEF.md
# Per-Rank Activate Window Limiter

This block sits beside the bank machines of a DRAM controller and keeps each rank within its budget of row activations over a rolling interval. The bank machines report every activate they send with a one-cycle strobe and a rank index. Each rank has its own permanently assigned tracker. The tracker remembers recent activates to its rank, one down-counter per permitted activate. It raises that rank's inhibit once the number of activates still inside the interval reaches the configured budget.

The inhibit drops as soon as the oldest tracked activate leaves the interval, which frees room for one more. The interval length in controller cycles and the per-rank budget come from configuration inputs. These are held steady while the block is out of reset. The bank machines must not send an activate to a rank whose inhibit is high in that cycle.

Top module: `act_window_limiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, every inhibit output is low and no earlier activate is remembered.
- R2: An activate counts only toward the rank named by its rank index. The inhibit of any other rank is unaffected by it.
- R3: With an interval of W cycles (W of 2 or more) and an effective budget L, an activate sent in cycle t is counted in cycles t+1 through t+W-1. A rank's inhibit is high in cycle c exactly when at least L of its activates are counted in c. An activate that fills the budget is therefore accepted, and the inhibit appears in the following cycle.
- R4: The inhibit falls in the cycle in which the oldest counted activate reaches age W. That cycle is t+W for an activate sent in cycle t.
- R5: The budget input is clamped. A value of 0 acts as 1, and a value above the MAX_ACTS parameter acts as MAX_ACTS.
- R6: An interval setting of 0 or 1 imposes no restriction, so no inhibit is ever raised.
- R7: An activate strobe whose rank index is NUM_RANKS or above is ignored. In the cycle after it, no inhibit rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_valid | input | 1 | An activate was sent in this cycle |
| act_rank | input | RANK_W | Rank index of that activate |
| cfg_window | input | WIN_W | Interval length in cycles |
| cfg_limit | input | LIM_W | Activates allowed per interval per rank |
| act_inhibit | output | NUM_RANKS | Per-rank block on further activates |

## Verification
The properties take two things for granted. First, the interval and budget inputs change only while reset is held. Second, no activate is sent to a rank whose inhibit is high in that cycle. Both assumptions are also checked as properties.

The bench meets them by applying each configuration under reset. It decides every activate from its own arithmetic model of the counted history, so it never sends an activate that the model says is blocked. Stray rank indices are sent freely, because no inhibit guards them.

// File: rtl/awl_pkg.sv
package awl_pkg;

    // Budget clamp: zero behaves as one, anything above the slot count saturates.
    function automatic int unsigned clamp_budget(int unsigned raw, int unsigned slots);
        if (raw == 0) begin
            return 1;
        end
        if (raw > slots) begin
            return slots;
        end
        return raw;
    endfunction

    // Cycles a slot stays occupied after the cycle of the activate itself.
    function automatic int unsigned hold_length(int unsigned interval);
        return (interval > 1) ? interval - 1 : 0;
    endfunction

endpackage

// File: rtl/awl_rank_decode.sv
module awl_rank_decode #(
    parameter int NUM_RANKS = 3,
    parameter int RANK_W    = 2
) (
    input  logic              strobe,
    input  logic [RANK_W-1:0] rank_idx,
    output logic [NUM_RANKS-1:0] hit
);

    // One compare per rank; an index with no matching rank sets no bit.
    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_hit
        assign hit[r] = strobe && (rank_idx == RANK_W'(r));
    end

endmodule

// File: rtl/awl_slot_timer.sv
module awl_slot_timer #(
    parameter int MAX_ACTS = 4,
    parameter int CNT_W    = 8,
    parameter int OCC_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [OCC_W-1:0] occupied_d
);

    typedef struct packed {
        logic [MAX_ACTS-1:0][CNT_W-1:0] remain;
    } slot_state_t;

    slot_state_t st_d;
    slot_state_t st_q;

    always_comb begin
        logic placed;
        st_d       = st_q;
        placed     = 1'b0;
        occupied_d = '0;
        for (int i = 0; i < MAX_ACTS; i++) begin
            if (st_q.remain[i] != '0) begin
                st_d.remain[i] = st_q.remain[i] - 1'b1;
            end else if (load_en && !placed && (load_val != '0)) begin
                // lowest free slot takes the new activate
                st_d.remain[i] = load_val;
                placed         = 1'b1;
            end
            if (st_d.remain[i] != '0) begin
                occupied_d = occupied_d + OCC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/awl_rank_gate.sv
module awl_rank_gate #(
    parameter int MAX_ACTS = 4,
    parameter int CNT_W    = 8,
    parameter int LIM_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [CNT_W-1:0] hold_val,
    input  logic [LIM_W-1:0] budget,
    output logic             inhibit
);

    typedef struct packed {
        logic blocked;
    } gate_state_t;

    gate_state_t      st_d;
    gate_state_t      st_q;
    logic [LIM_W-1:0] occupied_d;

    awl_slot_timer #(
        .MAX_ACTS (MAX_ACTS),
        .CNT_W    (CNT_W),
        .OCC_W    (LIM_W)
    ) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (hit),
        .load_val   (hold_val),
        .occupied_d (occupied_d)
    );

    // Decided from next-cycle occupancy, so a filling activate blocks from the next cycle.
    always_comb begin
        st_d         = st_q;
        st_d.blocked = (occupied_d >= budget);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inhibit = st_q.blocked;

endmodule

// File: rtl/act_window_limiter.sv
module act_window_limiter #(
    parameter int NUM_RANKS = 3,
    parameter int MAX_ACTS  = 4,
    parameter int WIN_W     = 8,
    localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int LIM_W    = $clog2(MAX_ACTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 act_valid,
    input  logic [RANK_W-1:0]    act_rank,
    input  logic [WIN_W-1:0]     cfg_window,
    input  logic [LIM_W-1:0]     cfg_limit,
    output logic [NUM_RANKS-1:0] act_inhibit
);

    logic [NUM_RANKS-1:0] rank_hit;
    logic [LIM_W-1:0]     budget_eff;
    logic [WIN_W-1:0]     hold_val;

    // Configuration shaping is shared by every rank.
    always_comb begin
        budget_eff = LIM_W'(awl_pkg::clamp_budget(int'(cfg_limit), MAX_ACTS));
        hold_val   = WIN_W'(awl_pkg::hold_length(int'(cfg_window)));
    end

    awl_rank_decode #(
        .NUM_RANKS (NUM_RANKS),
        .RANK_W    (RANK_W)
    ) u_decode (
        .strobe   (act_valid),
        .rank_idx (act_rank),
        .hit      (rank_hit)
    );

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        awl_rank_gate #(
            .MAX_ACTS (MAX_ACTS),
            .CNT_W    (WIN_W),
            .LIM_W    (LIM_W)
        ) u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (rank_hit[r]),
            .hold_val (hold_val),
            .budget   (budget_eff),
            .inhibit  (act_inhibit[r])
        );
    end

endmodule

// File: rtl/awl_checker.sv
module awl_checker #(
    parameter int NUM_RANKS = 3,
    parameter int RANK_W    = 2,
    parameter int WIN_W     = 8,
    parameter int LIM_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 act_valid,
    input logic [RANK_W-1:0]    act_rank,
    input logic [WIN_W-1:0]     cfg_window,
    input logic [LIM_W-1:0]     cfg_limit,
    input logic [NUM_RANKS-1:0] act_inhibit
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (act_inhibit == '0));

    // Input assumption: configuration only moves under reset
    cfg_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg_window) && $stable(cfg_limit));

    // R6
    short_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_window <= WIN_W'(1)) |-> (act_inhibit == '0));

    // R7
    stray_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && (int'(act_rank) >= NUM_RANKS))
        |=> ((act_inhibit & ~$past(act_inhibit)) == '0));

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank_chk
        // Input assumption: no activate to a blocked rank
        legal_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act_valid && (act_rank == RANK_W'(r))) |-> !act_inhibit[r]);

        // R2
        own_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(act_inhibit[r]) |-> $past(act_valid && (act_rank == RANK_W'(r))));

        // R3
        single_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act_valid && (act_rank == RANK_W'(r)) && (cfg_window > WIN_W'(1))
             && (cfg_limit <= LIM_W'(1)))
            |=> act_inhibit[r]);
    end

endmodule

bind act_window_limiter awl_checker #(
    .NUM_RANKS (NUM_RANKS),
    .RANK_W    (RANK_W),
    .WIN_W     (WIN_W),
    .LIM_W     (LIM_W)
) u_awl_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .act_valid   (act_valid),
    .act_rank    (act_rank),
    .cfg_window  (cfg_window),
    .cfg_limit   (cfg_limit),
    .act_inhibit (act_inhibit)
);

// File: tb/act_window_limiter_test.sv
module act_window_limiter_test;

    localparam int NR = 3;
    localparam int MA = 4;
    localparam int WW = 8;
    localparam int RW = 2;
    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          act_valid = 1'b0;
    logic [RW-1:0] act_rank = '0;
    logic [WW-1:0] cfg_window = '0;
    logic [LW-1:0] cfg_limit = '0;
    logic [NR-1:0] act_inhibit;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int hist [NR][MA];
    int cyc;
    int cur_win;
    int cur_lim;

    act_window_limiter #(
        .NUM_RANKS (NR),
        .MAX_ACTS  (MA),
        .WIN_W     (WW)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_valid   (act_valid),
        .act_rank    (act_rank),
        .cfg_window  (cfg_window),
        .cfg_limit   (cfg_limit),
        .act_inhibit (act_inhibit)
    );

    always #4 clk = ~clk;

    function automatic int eff_budget(int raw);
        if (raw == 0) return 1;
        if (raw > MA) return MA;
        return raw;
    endfunction

    // Expected inhibit of rank r in the current cycle (R3, R4, R5, R6)
    function automatic bit model_block(int r);
        int n;
        if (cur_win <= 1) return 1'b0;
        n = 0;
        for (int i = 0; i < MA; i++) begin
            if ((cyc - hist[r][i]) < cur_win) n++;
        end
        return n >= eff_budget(cur_lim);
    endfunction

    task automatic check(bit ok, string tag, logic [NR-1:0] got, logic [NR-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act_inhibit=%b expected %b (window=%0d budget=%0d cycle=%0d)",
                     tag, got, exp, cur_win, cur_lim, cyc);
        end
    endtask

    task automatic run_case(int win, int lim, int pat, int len);
        logic [7:0]    lfsr;
        logic [NR-1:0] exp;
        string         tag;
        bit            was_stray;
        cur_win    = win;
        cur_lim    = lim;
        rst_n      = 1'b0;
        act_valid  = 1'b0;
        act_rank   = '0;
        cfg_window = WW'(win);
        cfg_limit  = LW'(lim);
        repeat (2) @(negedge clk);
        check(act_inhibit == '0, "R1", act_inhibit, '0);
        for (int r = 0; r < NR; r++) begin
            for (int i = 0; i < MA; i++) hist[r][i] = -100000;
        end
        lfsr      = 8'(8'h5B ^ (win * 13 + lim * 7 + pat));
        if (lfsr == 8'h00) lfsr = 8'h01;
        was_stray = 1'b0;
        rst_n     = 1'b1;
        cyc       = 0;
        for (int k = 0; k < len; k++) begin
            int  tgt;
            bit  want;
            for (int r = 0; r < NR; r++) exp[r] = model_block(r);
            if (act_inhibit != exp) begin
                if (k == 0) tag = "R1";
                else if (was_stray) tag = "R7";
                else if (win <= 1) tag = "R6";
                else if (lim == 0 || lim > MA) tag = "R5";
                else if ((exp & ~act_inhibit) != '0) tag = "R3";
                else tag = "R4 or R2";
            end else begin
                tag = "R3";
            end
            check(act_inhibit == exp, tag, act_inhibit, exp);
            // choose this cycle's activate
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (pat)
                0:       begin tgt = 0;          want = 1'b1;    end
                1:       begin tgt = k % 4;      want = 1'b1;    end
                default: begin tgt = int'(lfsr[2:1]); want = lfsr[0]; end
            endcase
            if (want && tgt < NR && exp[tgt]) want = 1'b0;
            act_valid = want;
            act_rank  = RW'(tgt);
            was_stray = want && (tgt >= NR);
            if (want && tgt < NR) begin
                for (int i = MA - 1; i > 0; i--) hist[tgt][i] = hist[tgt][i-1];
                hist[tgt][0] = cyc;
            end
            @(negedge clk);
            cyc++;
        end
        act_valid = 1'b0;
    endtask

    initial begin
        int wins [6] = '{0, 1, 2, 3, 5, 9};
        for (int w = 0; w < 6; w++) begin
            for (int l = 0; l < 8; l++) begin
                for (int p = 0; p < 3; p++) begin
                    run_case(wins[w], l, p, 40);
                end
            end
        end
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule